// File: doc/BRIEF.md
# Double-Buffered Mode Word Switcher

This block keeps a fabric mode-control word in two copies. The active copy drives the fabric through a dedicated output. The pending copy is the only one software can write. A new value therefore takes effect only through a guarded switch operation, never through a plain register write. That operation is started from a command register, and only while a lock bit is held. It then walks through fixed phases: it asks the fabric to go quiet, waits a programmable count, exchanges the two copies, waits a second programmable count, and signals a reinitialisation.

One unit in the system acts as master, marked by bit 0 of its active word, and only that unit may start the operation. Its switch strobe is fanned out to the other units. Every unit, including the master, exchanges its copies on a strobe only when its switch-enable input is high. Software raises switch-enable before the operation and lowers it afterwards. Once the exchange is done, software writes the new value into the pending copy again so that both copies agree.

The quiesce handshake is guarded by a timeout. A start that arrives while the sequencer is busy is dropped and recorded.

Top module: `modeword_switcher`

## Requirements
- R1: After reset the following hold. The active copy equals parameter ACTIVE_INIT (default 0) and the pending copy is 0. Busy, done, error, overrun, lock and quiesce request are all 0. The after-quiesce wait (address 2) and the before-init wait (address 3) both read 128. The option register (address 1) reads 3.
- R2: A write to address 4 changes only the pending copy, which reads back at address 4. The active copy (output and address 5) stays unchanged.
- R3: An accepted start with the quiesce option set behaves as follows. Quiesce request rises in the cycle after the start write. Let N be the after-quiesce count and M the before-init count. The one-cycle switch strobe begins N+1 edges after the edge that samples the acknowledge. The one-cycle reinit strobe begins M+2 edges after the switch strobe. Done and idle follow one edge later, and quiesce request falls in that same cycle.
- R4: On a switch strobe with switch-enable high, the active and pending copies exchange values.
- R5: On a switch strobe with switch-enable low, neither copy changes.
- R6: With option bit 0 (quiesce step) clear, no quiesce request is made and the switch strobe comes in the cycle right after the start write.
- R7: With option bit 1 (reinit step) clear, no reinit strobe is made and done follows the switch strobe by one edge.
- R8: A start is accepted only if all of these hold: the lock was already held before the write; the write has bit 0 (lock) and bit 1 (start) set; bit 2 is clear; scope bits [6:4] equal 3'b101; type bits [13:7] equal 7'b0110001. Any other start does nothing. Bit 0 of each write to address 0 becomes the new lock state.
- R9: A unit whose active word has bit 0 clear ignores starts. Such a unit still exchanges its copies on the external switch strobe input when its switch-enable is high.
- R10: Suppose the acknowledge has not arrived within TMO_CYC cycles of the quiesce request. The error flag then sets, the quiesce request drops, the sequencer returns to idle, and no exchange happens.
- R11: Writing address 0 with bit 2 set returns the sequencer to idle and drops the quiesce request by the next cycle. No exchange follows.
- R12: Writing address 0 with bit 3 set clears the done, error and overrun flags. The status read at address 0 has lock in bit 0, busy in bit 1, done in bit 2, error in bit 3 and overrun in bit 4.
- R13: A start that would otherwise be accepted but arrives while busy is ignored and sets the sticky overrun flag. The running operation keeps its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W | Register address for writes and reads |
| reg_wdata | input | DATA_W | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| active_word | output | WORD_W | Active copy of the mode word |
| quiesce_req | output | 1 | Request for the fabric to go quiet |
| quiesce_ack | input | 1 | Fabric is quiet |
| sw_en | input | 1 | This unit may exchange its copies |
| sw_pulse_in | input | 1 | Switch strobe from the master unit |
| sw_pulse_out | output | 1 | Switch strobe issued by this unit |
| reinit_pulse | output | 1 | Reinitialise strobe |
| busy | output | 1 | Switch operation in progress |
| done | output | 1 | Sticky: last operation completed |
| err | output | 1 | Sticky: quiesce acknowledge timed out |

## Verification
The switch operation is run with small counts (3 and 5), with both counts at zero, and with the default 128. Together these show that each count is applied in its own phase and that the zero corner still gives one cycle per phase. Runs with each option bit cleared on its own show that the quiesce step and the reinit step can be skipped independently. A run with switch-enable low shows that the strobe and the exchange are separate from each other. Rejected starts are tried one per guard (wrong scope, wrong type, lock not held, non-master unit, busy) so that each guard is seen to block on its own. A missing acknowledge and a mid-run state-machine reset then check the two ways an operation is aborted.

// File: rtl/msw_pkg.sv
// Package: shared state encoding, register addresses and command bit
// positions for the mode word switcher.
package msw_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_QREQ,
        SQ_QWAIT,
        SQ_SWAP,
        SQ_IWAIT,
        SQ_INIT
    } sq_state_t;

    // Register addresses
    localparam int unsigned RA_CTRL  = 0;
    localparam int unsigned RA_OPT   = 1;
    localparam int unsigned RA_QWAIT = 2;
    localparam int unsigned RA_IWAIT = 3;
    localparam int unsigned RA_PEND  = 4;
    localparam int unsigned RA_ACT   = 5;

    // Command word bit positions
    localparam int unsigned CB_LOCK     = 0;
    localparam int unsigned CB_START    = 1;
    localparam int unsigned CB_RSTSEQ   = 2;
    localparam int unsigned CB_CLRST    = 3;
    localparam int unsigned CB_SCOPE_LO = 4;
    localparam int unsigned CB_KIND_LO  = 7;

    localparam logic [2:0] SCOPE_SYS = 3'b101;
    localparam logic [6:0] KIND_MISC = 7'b0110001;

    // Option bit positions
    localparam int unsigned OB_PRE  = 0;
    localparam int unsigned OB_POST = 1;

endpackage

// File: rtl/msw_regs.sv
// Module: msw_regs
// Holds the active and pending copies of the mode word plus the option and
// wait-count registers. Copies exchange only on a switch request while the
// unit's switch enable is high. Assumes DATA_W covers WORD_W and QW_W.
module msw_regs
    import msw_pkg::*;
#(
    parameter int unsigned WORD_W      = 16,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 3,
    parameter int unsigned QW_W        = 20,
    parameter int unsigned IW_W        = 10,
    parameter logic [WORD_W-1:0] ACTIVE_INIT = '0,
    parameter int unsigned QW_INIT     = 128,
    parameter int unsigned IW_INIT     = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              swap_req,
    input  logic              sw_en,
    output logic [WORD_W-1:0] active_q,
    output logic [WORD_W-1:0] pending_q,
    output logic              pre_en,
    output logic              post_en,
    output logic [QW_W-1:0]   qwait_q,
    output logic [IW_W-1:0]   iwait_q
);

    logic swap_do;

    // Exchange only when this unit is enabled for the switch
    assign swap_do = swap_req && sw_en;

    // Mode word copies: exchange on swap, pending also written by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q  <= ACTIVE_INIT;
            pending_q <= '0;
        end else begin
            if (swap_do) begin
                active_q  <= pending_q;
                pending_q <= active_q;
            end
            if (we && addr == ADDR_W'(RA_PEND)) begin
                pending_q <= wdata[WORD_W-1:0];
            end
        end
    end

    // Option bits and wait counts written by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_en  <= 1'b1;
            post_en <= 1'b1;
            qwait_q <= QW_W'(QW_INIT);
            iwait_q <= IW_W'(IW_INIT);
        end else if (we) begin
            if (addr == ADDR_W'(RA_OPT)) begin
                pre_en  <= wdata[OB_PRE];
                post_en <= wdata[OB_POST];
            end
            if (addr == ADDR_W'(RA_QWAIT)) qwait_q <= wdata[QW_W-1:0];
            if (addr == ADDR_W'(RA_IWAIT)) iwait_q <= wdata[IW_W-1:0];
        end
    end

    assert_hold_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_do |=> $stable(active_q));

    assert_exchange_R4: assert property (@(posedge clk) disable iff (!rst_n)
        swap_do |=> active_q == $past(pending_q));

    assert_disabled_unit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_req && !sw_en) |=> $stable(active_q));

endmodule

// File: rtl/msw_cmd.sv
// Module: msw_cmd
// Decodes command register writes: lock state, start qualification
// (lock, scope, type, master), sequencer reset, and the sticky done, error
// and overrun flags. Assumes busy and the events come from the sequencer.
module msw_cmd
    import msw_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              master,
    input  logic              busy,
    input  logic              done_evt,
    input  logic              err_evt,
    output logic              go,
    output logic              fsm_clr,
    output logic              lock_q,
    output logic              done_q,
    output logic              err_q,
    output logic              ovr_q
);

    logic       cmd_wr;
    logic       start_ok;
    logic [2:0] scope;
    logic [6:0] kind;

    // Field extraction from the command word
    assign cmd_wr  = we && addr == ADDR_W'(RA_CTRL);
    assign scope   = wdata[CB_SCOPE_LO +: 3];
    assign kind    = wdata[CB_KIND_LO +: 7];
    assign fsm_clr = cmd_wr && wdata[CB_RSTSEQ];

    // A start qualifies only under a held lock, correct fields, on the master
    assign start_ok = cmd_wr && lock_q && wdata[CB_LOCK] && wdata[CB_START]
                      && !wdata[CB_RSTSEQ] && scope == SCOPE_SYS
                      && kind == KIND_MISC && master;
    assign go = start_ok && !busy;

    // Lock state and sticky status flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (cmd_wr) lock_q <= wdata[CB_LOCK];
            if (cmd_wr && wdata[CB_CLRST]) begin
                done_q <= 1'b0;
                err_q  <= 1'b0;
                ovr_q  <= 1'b0;
            end
            if (go)       done_q <= 1'b0;
            if (done_evt) done_q <= 1'b1;
            if (err_evt)  err_q  <= 1'b1;
            if (start_ok && busy) ovr_q <= 1'b1;
        end
    end

    assert_go_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> busy);

    assert_guarded_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(lock_q));

    assert_master_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(master));

    assert_overrun_flag_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ok && busy) |=> ovr_q);

    assert_clear_status_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && wdata[CB_CLRST] && !err_evt) |=> !err_q);

endmodule

// File: rtl/msw_seq.sv
// Module: msw_seq
// Switch sequencer: optional quiesce request with acknowledge timeout,
// after-quiesce wait, one-cycle switch strobe, before-init wait, optional
// reinit strobe. Option bits are latched at start. A wait of count C
// spends C+1 cycles in its phase.
module msw_seq
    import msw_pkg::*;
#(
    parameter int unsigned QW_W    = 20,
    parameter int unsigned IW_W    = 10,
    parameter int unsigned TMO_CYC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic            fsm_clr,
    input  logic            pre_en,
    input  logic            post_en,
    input  logic [QW_W-1:0] qwait,
    input  logic [IW_W-1:0] iwait,
    input  logic            quiesce_ack,
    output logic            quiesce_req,
    output logic            swap_go,
    output logic            reinit_go,
    output logic            busy,
    output logic            done_evt,
    output logic            err_evt
);

    localparam int unsigned CNT_W = (QW_W > IW_W) ? QW_W : IW_W;
    localparam int unsigned TMO_W = $clog2(TMO_CYC + 1);

    sq_state_t        state;
    logic [CNT_W-1:0] cnt;
    logic [TMO_W-1:0] tcnt;
    logic             q_held;
    logic             pre_q;
    logic             post_q;
    logic             tmo_hit;

    // Decoded strobes and events
    assign tmo_hit     = tcnt == TMO_W'(TMO_CYC - 1);
    assign busy        = state != SQ_IDLE;
    assign quiesce_req = q_held;
    assign swap_go     = state == SQ_SWAP && !fsm_clr;
    assign reinit_go   = state == SQ_INIT && !fsm_clr;
    assign done_evt    = !fsm_clr && (state == SQ_INIT || (state == SQ_SWAP && !post_q));
    assign err_evt     = !fsm_clr && state == SQ_QREQ && !quiesce_ack && tmo_hit;

    // Phase sequencing with wait and timeout counters
    always_ff @(posedge clk) begin
        if (!rst_n || fsm_clr) begin
            state  <= SQ_IDLE;
            cnt    <= '0;
            tcnt   <= '0;
            q_held <= 1'b0;
            pre_q  <= 1'b0;
            post_q <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (go) begin
                        pre_q  <= pre_en;
                        post_q <= post_en;
                        tcnt   <= '0;
                        if (pre_en) begin
                            state  <= SQ_QREQ;
                            q_held <= 1'b1;
                        end else begin
                            state <= SQ_SWAP;
                        end
                    end
                end
                SQ_QREQ: begin
                    if (quiesce_ack) begin
                        state <= SQ_QWAIT;
                        cnt   <= CNT_W'(qwait);
                    end else if (tmo_hit) begin
                        state  <= SQ_IDLE;
                        q_held <= 1'b0;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                SQ_QWAIT: begin
                    if (cnt == '0) state <= SQ_SWAP;
                    else           cnt   <= cnt - 1'b1;
                end
                SQ_SWAP: begin
                    if (post_q) begin
                        state <= SQ_IWAIT;
                        cnt   <= CNT_W'(iwait);
                    end else begin
                        state  <= SQ_IDLE;
                        q_held <= 1'b0;
                    end
                end
                SQ_IWAIT: begin
                    if (cnt == '0) state <= SQ_INIT;
                    else           cnt   <= cnt - 1'b1;
                end
                SQ_INIT: begin
                    state  <= SQ_IDLE;
                    q_held <= 1'b0;
                end
                default: begin
                    state  <= SQ_IDLE;
                    q_held <= 1'b0;
                end
            endcase
        end
    end

    assert_quiesced_swap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_go && pre_q) |-> quiesce_req);

    assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        swap_go |=> !swap_go);

    assert_no_quiesce_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pre_q) |-> !quiesce_req);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> !busy);

    assert_timeout_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |=> (!busy && !quiesce_req));

    assert_seq_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_clr |=> (!busy && !quiesce_req));

endmodule

// File: rtl/modeword_switcher.sv
// Module: modeword_switcher (top)
// Double-buffered mode word with a locked quiesce/wait/swap/wait/reinit
// switch sequence. The master role comes from bit 0 of the active word.
// Local exchanges follow either the own strobe or the external strobe,
// gated by sw_en. Read data is combinational from reg_addr.
module modeword_switcher
    import msw_pkg::*;
#(
    parameter int unsigned WORD_W      = 16,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 3,
    parameter int unsigned QW_W        = 20,
    parameter int unsigned IW_W        = 10,
    parameter int unsigned TMO_CYC     = 32,
    parameter logic [WORD_W-1:0] ACTIVE_INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [WORD_W-1:0] active_word,
    output logic              quiesce_req,
    input  logic              quiesce_ack,
    input  logic              sw_en,
    input  logic              sw_pulse_in,
    output logic              sw_pulse_out,
    output logic              reinit_pulse,
    output logic              busy,
    output logic              done,
    output logic              err
);

    localparam int unsigned ST_W = 5;

    logic [WORD_W-1:0] active_q;
    logic [WORD_W-1:0] pending_q;
    logic              pre_en;
    logic              post_en;
    logic [QW_W-1:0]   qwait_q;
    logic [IW_W-1:0]   iwait_q;
    logic              go;
    logic              fsm_clr;
    logic              lock_q;
    logic              ovr_q;
    logic              swap_go;
    logic              done_evt;
    logic              err_evt;
    logic              seq_busy;
    logic [ST_W-1:0]   status;

    msw_regs #(
        .WORD_W(WORD_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .QW_W(QW_W), .IW_W(IW_W), .ACTIVE_INIT(ACTIVE_INIT),
        .QW_INIT(128), .IW_INIT(128)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .swap_req(swap_go || sw_pulse_in), .sw_en(sw_en),
        .active_q(active_q), .pending_q(pending_q), .pre_en(pre_en), .post_en(post_en),
        .qwait_q(qwait_q), .iwait_q(iwait_q)
    );

    msw_cmd #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cmd (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .master(active_q[0]), .busy(seq_busy), .done_evt(done_evt), .err_evt(err_evt),
        .go(go), .fsm_clr(fsm_clr), .lock_q(lock_q), .done_q(done), .err_q(err),
        .ovr_q(ovr_q)
    );

    msw_seq #(.QW_W(QW_W), .IW_W(IW_W), .TMO_CYC(TMO_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .fsm_clr(fsm_clr),
        .pre_en(pre_en), .post_en(post_en), .qwait(qwait_q), .iwait(iwait_q),
        .quiesce_ack(quiesce_ack), .quiesce_req(quiesce_req), .swap_go(swap_go),
        .reinit_go(reinit_pulse), .busy(seq_busy), .done_evt(done_evt), .err_evt(err_evt)
    );

    assign active_word  = active_q;
    assign sw_pulse_out = swap_go;
    assign busy         = seq_busy;
    assign status       = {ovr_q, err, done, seq_busy, lock_q};

    // Read-back multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(RA_CTRL):  reg_rdata = DATA_W'(status);
            ADDR_W'(RA_OPT):   reg_rdata = DATA_W'({post_en, pre_en});
            ADDR_W'(RA_QWAIT): reg_rdata = DATA_W'(qwait_q);
            ADDR_W'(RA_IWAIT): reg_rdata = DATA_W'(iwait_q);
            ADDR_W'(RA_PEND):  reg_rdata = DATA_W'(pending_q);
            ADDR_W'(RA_ACT):   reg_rdata = DATA_W'(active_q);
            default:           reg_rdata = '0;
        endcase
    end

    assert_strobe_needs_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sw_pulse_out |-> busy);

endmodule

// File: tb/sim_modeword_switcher.sv
module sim_modeword_switcher;

    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 20;
    localparam int WORD_W     = 16;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 3;

    localparam logic [31:0] C_LOCK   = 32'h0000_000D; // lock|reset-seq|clear
    localparam logic [31:0] C_START  = 32'h0000_18D3; // lock|start|scope101|type0110001
    localparam logic [31:0] C_BADSC  = 32'h0000_18C3; // scope 100
    localparam logic [31:0] C_BADTY  = 32'h0000_1853; // type 0110000
    localparam logic [31:0] C_RSTSEQ = 32'h0000_0005; // lock|reset-seq
    localparam logic [31:0] C_CLR    = 32'h0000_0009; // lock|clear

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic              reg_we = 1'b0;
    logic [DATA_W-1:0] reg_rdata;
    logic [WORD_W-1:0] active_word;
    logic              quiesce_req;
    logic              quiesce_ack = 1'b0;
    logic              sw_en = 1'b0;
    logic              sw_pulse_in = 1'b0;
    logic              sw_pulse_out;
    logic              reinit_pulse;
    logic              busy;
    logic              done;
    logic              err;

    logic ack_mode = 1'b1;
    int   total = 0;
    int   bad = 0;
    int   cyc = 0;
    int   sw_i, ri_i, dn_i, q_cnt, sw_cnt, b_cnt;

    modeword_switcher #(.TMO_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .active_word(active_word),
        .quiesce_req(quiesce_req), .quiesce_ack(quiesce_ack), .sw_en(sw_en),
        .sw_pulse_in(sw_pulse_in), .sw_pulse_out(sw_pulse_out),
        .reinit_pulse(reinit_pulse), .busy(busy), .done(done), .err(err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Fabric model: acknowledge follows the request when enabled
    always @(negedge clk) quiesce_ack <= ack_mode && quiesce_req;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        reg_addr = ADDR_W'(a);
        reg_wdata = d;
        reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        reg_addr = ADDR_W'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic setup(logic pre, logic post, int n, int m);
        wr(1, {30'd0, post, pre});
        wr(2, n);
        wr(3, m);
    endtask

    // Sample from the current negedge (index 0) for n cycles
    task automatic watch(int n);
        sw_i = -1; ri_i = -1; dn_i = -1; q_cnt = 0; sw_cnt = 0; b_cnt = 0;
        for (int i = 0; i < n; i++) begin
            if (sw_pulse_out) begin sw_cnt++; if (sw_i < 0) sw_i = i; end
            if (reinit_pulse && ri_i < 0) ri_i = i;
            if (done && dn_i < 0) dn_i = i;
            if (quiesce_req) q_cnt++;
            if (busy) b_cnt++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(0, d); check("R1 status", d, 0);
        rd(1, d); check("R1 options", d, 3);
        rd(2, d); check("R1 qwait", d, 128);
        rd(3, d); check("R1 iwait", d, 128);
        rd(4, d); check("R1 pending", d, 0);
        check("R1 active", active_word, 0);
        check("R1 quiesce_req", quiesce_req, 0);
    endtask

    task automatic t_nonmaster_R9();
        logic [31:0] d;
        wr(0, C_LOCK);
        wr(0, C_START);
        watch(10);
        check("R9 non-master start busy cycles", b_cnt, 0);
        check("R9 non-master no strobe", sw_cnt, 0);
        wr(4, 32'h0001);
        sw_en = 1'b1;
        @(negedge clk); sw_pulse_in = 1'b1;
        @(negedge clk); sw_pulse_in = 1'b0;
        check("R9 external strobe active", active_word, 16'h0001);
        rd(4, d); check("R9 external strobe pending", d, 0);
    endtask

    task automatic t_pending_R2();
        logic [31:0] d;
        wr(4, 32'hA5A5);
        rd(4, d); check("R2 pending readback", d, 32'hA5A5);
        rd(5, d); check("R2 active unchanged", d, 32'h0001);
        check("R2 active port", active_word, 16'h0001);
    endtask

    task automatic t_switch_R3_R4();
        logic [31:0] d;
        setup(1, 1, 3, 5);
        wr(0, C_START);
        check("R3 request at start", quiesce_req, 1);
        watch(20);
        check("R3 strobe index", sw_i, 5);
        check("R3 strobe count", sw_cnt, 1);
        check("R3 reinit index", ri_i, 12);
        check("R3 done index", dn_i, 13);
        check("R3 quiesce cycles", q_cnt, 13);
        check("R4 active after swap", active_word, 16'hA5A5);
        rd(4, d); check("R4 pending after swap", d, 32'h0001);
        wr(4, 32'hA5A5);
    endtask

    task automatic t_default_R3();
        setup(1, 1, 128, 128);
        wr(0, C_START);
        watch(300);
        check("R3 default strobe index", sw_i, 130);
        check("R3 default reinit index", ri_i, 260);
        check("R3 default done index", dn_i, 261);
    endtask

    task automatic t_zero_R3();
        setup(1, 1, 0, 0);
        wr(0, C_START);
        watch(10);
        check("R3 zero-count strobe index", sw_i, 2);
        check("R3 zero-count reinit index", ri_i, 4);
        check("R3 zero-count done index", dn_i, 5);
    endtask

    task automatic t_swen_R5();
        logic [31:0] d;
        wr(4, 32'h0F01);
        sw_en = 1'b0;
        setup(0, 0, 0, 0);
        wr(0, C_START);
        watch(5);
        check("R5 strobe issued", sw_cnt, 1);
        check("R5 active unchanged", active_word, 16'hA5A5);
        rd(4, d); check("R5 pending unchanged", d, 32'h0F01);
        sw_en = 1'b1;
        wr(4, 32'hA5A5);
    endtask

    task automatic t_pre_off_R6();
        setup(0, 1, 3, 5);
        wr(0, C_START);
        watch(15);
        check("R6 strobe index", sw_i, 0);
        check("R6 no quiesce", q_cnt, 0);
        check("R6 reinit index", ri_i, 7);
        check("R6 done index", dn_i, 8);
    endtask

    task automatic t_post_off_R7();
        setup(1, 0, 3, 5);
        wr(0, C_START);
        watch(15);
        check("R7 strobe index", sw_i, 5);
        check("R7 no reinit", ri_i, -1);
        check("R7 done index", dn_i, 6);
        check("R7 quiesce cycles", q_cnt, 6);
    endtask

    task automatic t_guard_R8();
        setup(1, 1, 0, 0);
        wr(0, C_BADSC);
        watch(5);
        check("R8 wrong scope ignored", b_cnt, 0);
        wr(0, C_BADTY);
        watch(5);
        check("R8 wrong type ignored", b_cnt, 0);
        wr(0, 0);
        wr(0, C_START);
        watch(5);
        check("R8 unlocked start ignored", b_cnt, 0);
        wr(0, C_START);
        watch(10);
        check("R8 locked start accepted", sw_cnt, 1);
    endtask

    task automatic t_fsm_reset_R11();
        setup(1, 1, 50, 5);
        wr(4, 32'h00F1);
        wr(0, C_START);
        repeat (10) @(negedge clk);
        wr(0, C_RSTSEQ);
        check("R11 idle after reset", busy, 0);
        check("R11 request dropped", quiesce_req, 0);
        watch(70);
        check("R11 no strobe", sw_cnt, 0);
        check("R11 active unchanged", active_word, 16'hA5A5);
        wr(0, C_LOCK);
        wr(4, 32'hA5A5);
    endtask

    task automatic t_timeout_R10();
        logic [31:0] d;
        ack_mode = 1'b0;
        setup(1, 1, 0, 0);
        wr(0, C_START);
        repeat (TMO - 1) @(negedge clk);
        check("R10 request before timeout", quiesce_req, 1);
        @(negedge clk);
        check("R10 request dropped", quiesce_req, 0);
        check("R10 error flag", err, 1);
        check("R10 idle", busy, 0);
        watch(5);
        check("R10 no strobe", sw_cnt, 0);
        check("R10 active unchanged", active_word, 16'hA5A5);
        rd(0, d); check("R10 status error bit", d[3], 1);
        ack_mode = 1'b1;
    endtask

    task automatic t_overrun_R13();
        logic [31:0] d;
        setup(1, 1, 50, 5);
        wr(0, C_START);
        repeat (5) @(negedge clk);
        wr(0, C_START);
        rd(0, d); check("R13 overrun bit", d[4], 1);
        watch(80);
        check("R13 single strobe", sw_cnt, 1);
        check("R13 done", done, 1);
    endtask

    task automatic t_clear_R12();
        logic [31:0] d;
        rd(0, d); check("R12 flags before clear", d[4:2], 3'b111);
        wr(0, C_CLR);
        rd(0, d); check("R12 flags cleared", d[4:0], 5'b00001);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_nonmaster_R9();
        t_pending_R2();
        t_switch_R3_R4();
        t_default_R3();
        t_zero_R3();
        t_swen_R5();
        t_pre_off_R6();
        t_post_off_R7();
        t_guard_R8();
        t_fsm_reset_R11();
        t_timeout_R10();
        t_overrun_R13();
        t_clear_R12();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule